// File: doc/BRIEF.md
# Interrupt and Exception Entry Unit

This block sits beside a processor core and decides, each cycle, whether a non-maskable interrupt, a maskable interrupt or a synchronous exception is taken. The core presents the address of the current instruction, the address of the following instruction, its status word and any pending requests. When an event is accepted, the unit registers the whole entry sequence in one step. It saves the return address and the old status word into a save pair, writes the event code into one half of a 32-bit cause register, produces the new status word and outputs the redirect address the core must fetch from next.

Two save pairs exist. The normal pair serves ordinary interrupts and exceptions. The fatal pair serves the non-maskable interrupt and any exception raised while an earlier exception is still being handled. The normal pair writes the lower half of the cause register, and the fatal pair writes the upper half. A maskable interrupt passes through a gate that checks three status bits and compares its level with the current level.

Top module: `exc_entry_unit`

## Requirements
- R1: During and after reset, with no event, `taken` is 0, `redir_pc` is 0xFFFFFFF0, `psw_new` is 0x00008000, `ecr` is 0x0000FFF0, and all four save registers are 0.
- R2: A maskable interrupt is accepted only when status bits 15 (NMI pending), 14 (exception pending) and 12 (interrupt disable) are all 0. When it is refused, `taken` stays 0 and no register changes.
- R3: A maskable interrupt is accepted only when `irq_lvl` is greater than or equal to the level in status bits 19..16.
- R4: An ordinary entry (accepted interrupt, or exception while bit 14 is 0) stores the return address in `eipc` and the incoming status word in `eipsw`. It writes the code to `ecr[15:0]` and leaves `ecr[31:16]` and the fatal pair unchanged.
- R5: A fatal entry (NMI, or exception while bit 14 is 1) stores the return address in `fepc` and the incoming status word in `fepsw`. It writes the code to `ecr[31:16]` and leaves `ecr[15:0]` and the normal pair unchanged. The NMI code is 0xFFD0. Every fatal entry redirects to 0xFFFFFFD0.
- R6: The new status word is the incoming one with these changes: the level field is incremented and saturates at 15, and bits 14 and 12 are set. A fatal entry also sets bit 15. All other bits are kept.
- R7: An interrupt of level n has code 0xFEn0 and redirects to 0xFFFFFEn0. An ordinary exception writes its own code (for example 0xFF80 for divide by zero) and redirects to 0xFFFF0000 plus that code.
- R8: Interrupts, maskable or not, save `nxt_pc`. Exceptions save `cur_pc`.
- R9: The priority order is NMI first, then an accepted maskable interrupt, then an exception. A refused maskable interrupt does not hold back a pending exception.
- R10: All outputs are registered. `taken` and the new values appear one clock after the requests are sampled. In a cycle with no request, `taken` is 0 and every stored value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | Address of the instruction now executing |
| nxt_pc | input | 32 | Address of the following instruction |
| psw_in | input | 32 | Current status word |
| irq_req | input | 1 | Maskable interrupt request |
| irq_lvl | input | 4 | Level of the maskable request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 16 | Code of the exception |
| taken | output | 1 | Entry performed in the last cycle |
| redir_pc | output | 32 | Redirect address |
| psw_new | output | 32 | Status word after entry |
| eipc | output | 32 | Normal saved return address |
| eipsw | output | 32 | Normal saved status word |
| fepc | output | 32 | Fatal saved return address |
| fepsw | output | 32 | Fatal saved status word |
| ecr | output | 32 | Cause register, fatal code high, normal code low |

## Verification
Interrupt requests are applied against status words that have each of the three masking bits set one at a time. This shows that each bit blocks acceptance on its own. Levels just below, equal to and above the current level show where the comparison boundary lies. Exceptions are raised with the exception-pending bit clear and then set, which separates the normal path from the fatal one through the save pair, the cause half and the vector. Requests are also applied together (NMI with an interrupt, an accepted interrupt with an exception, a refused interrupt with an exception) to expose the priority order and the choice between the next and the current address.

// File: rtl/ee_pkg.sv
package ee_pkg;
    parameter int XLEN   = 32;
    parameter int CODE_W = 16;
    parameter int LVL_W  = 4;

    localparam int LVL_LO = 16;
    localparam int NP_BIT = 15;
    localparam int EP_BIT = 14;
    localparam int ID_BIT = 12;
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    localparam logic [XLEN-1:0]   RESET_PC   = 32'hFFFF_FFF0;
    localparam logic [XLEN-1:0]   RESET_PSW  = 32'h0000_8000;
    localparam logic [CODE_W-1:0] RESET_CODE = 16'hFFF0;
    localparam logic [CODE_W-1:0] NMI_CODE   = 16'hFFD0;
    localparam logic [7:0]        IRQ_PREFIX = 8'hFE;
    localparam logic [XLEN-CODE_W-1:0] VEC_HI = {(XLEN-CODE_W){1'b1}};

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_IRQ  = 2'd1,
        EV_EXC  = 2'd2,
        EV_NMI  = 2'd3
    } ev_kind_t;

    typedef struct packed {
        logic            taken;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] psw;
        logic [XLEN-1:0] eipc;
        logic [XLEN-1:0] eipsw;
        logic [XLEN-1:0] fepc;
        logic [XLEN-1:0] fepsw;
        logic [XLEN-1:0] ecr;
    } ee_state_t;
endpackage

// File: rtl/ee_select.sv
module ee_select
    import ee_pkg::*;
(
    input  logic             np_bit,
    input  logic             ep_bit,
    input  logic             id_bit,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic             nmi_req,
    input  logic             exc_req,
    output ev_kind_t         kind,
    output logic             fatal
);
    logic gate_open;
    logic lvl_ok;
    logic irq_ok;

    always_comb begin
        gate_open = ~np_bit & ~ep_bit & ~id_bit;
        lvl_ok    = (irq_lvl >= cur_lvl);
        irq_ok    = irq_req & gate_open & lvl_ok;

        if (nmi_req)      kind = EV_NMI;
        else if (irq_ok)  kind = EV_IRQ;
        else if (exc_req) kind = EV_EXC;
        else              kind = EV_NONE;

        fatal = (kind == EV_NMI) | ((kind == EV_EXC) & ep_bit);
    end
endmodule

// File: rtl/ee_psw_next.sv
module ee_psw_next
    import ee_pkg::*;
(
    input  logic [XLEN-1:0] psw_in,
    input  logic            fatal,
    output logic [XLEN-1:0] psw_out
);
    logic [LVL_W-1:0] lvl;
    logic [LVL_W-1:0] lvl_inc;

    always_comb begin
        lvl     = psw_in[LVL_LO +: LVL_W];
        lvl_inc = (lvl == LVL_MAX) ? LVL_MAX : lvl + 1'b1;
        psw_out = psw_in;
        psw_out[LVL_LO +: LVL_W] = lvl_inc;
        psw_out[EP_BIT] = 1'b1;
        psw_out[ID_BIT] = 1'b1;
        if (fatal) psw_out[NP_BIT] = 1'b1;
    end
endmodule

// File: rtl/ee_code_gen.sv
module ee_code_gen
    import ee_pkg::*;
(
    input  ev_kind_t          kind,
    input  logic              fatal,
    input  logic [LVL_W-1:0]  irq_lvl,
    input  logic [CODE_W-1:0] exc_code,
    output logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   vector
);
    always_comb begin
        case (kind)
            EV_NMI:  code = NMI_CODE;
            EV_IRQ:  code = {IRQ_PREFIX, irq_lvl, 4'h0};
            EV_EXC:  code = exc_code;
            default: code = '0;
        endcase
        vector = fatal ? {VEC_HI, NMI_CODE} : {VEC_HI, code};
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import ee_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   nxt_pc,
    input  logic [XLEN-1:0]   psw_in,
    input  logic              irq_req,
    input  logic [LVL_W-1:0]  irq_lvl,
    input  logic              nmi_req,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    output logic              taken,
    output logic [XLEN-1:0]   redir_pc,
    output logic [XLEN-1:0]   psw_new,
    output logic [XLEN-1:0]   eipc,
    output logic [XLEN-1:0]   eipsw,
    output logic [XLEN-1:0]   fepc,
    output logic [XLEN-1:0]   fepsw,
    output logic [XLEN-1:0]   ecr
);
    ev_kind_t          kind;
    logic              fatal;
    logic [XLEN-1:0]   psw_upd;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   vector;
    logic [XLEN-1:0]   ret_pc;
    ee_state_t         st_d, st_q;

    ee_select u_sel (
        .np_bit  (psw_in[NP_BIT]),
        .ep_bit  (psw_in[EP_BIT]),
        .id_bit  (psw_in[ID_BIT]),
        .cur_lvl (psw_in[LVL_LO +: LVL_W]),
        .irq_req (irq_req),
        .irq_lvl (irq_lvl),
        .nmi_req (nmi_req),
        .exc_req (exc_req),
        .kind    (kind),
        .fatal   (fatal)
    );

    ee_psw_next u_psw (
        .psw_in  (psw_in),
        .fatal   (fatal),
        .psw_out (psw_upd)
    );

    ee_code_gen u_code (
        .kind     (kind),
        .fatal    (fatal),
        .irq_lvl  (irq_lvl),
        .exc_code (exc_code),
        .code     (code),
        .vector   (vector)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        ret_pc     = (kind == EV_EXC) ? cur_pc : nxt_pc;
        if (kind != EV_NONE) begin
            st_d.taken = 1'b1;
            st_d.pc    = vector;
            st_d.psw   = psw_upd;
            if (fatal) begin
                st_d.fepc  = ret_pc;
                st_d.fepsw = psw_in;
                st_d.ecr[XLEN-1:CODE_W] = code;
            end else begin
                st_d.eipc  = ret_pc;
                st_d.eipsw = psw_in;
                st_d.ecr[CODE_W-1:0] = code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.pc    <= RESET_PC;
            st_q.psw   <= RESET_PSW;
            st_q.ecr   <= {{(XLEN-CODE_W){1'b0}}, RESET_CODE};
        end else begin
            st_q <= st_d;
        end
    end

    assign taken    = st_q.taken;
    assign redir_pc = st_q.pc;
    assign psw_new  = st_q.psw;
    assign eipc     = st_q.eipc;
    assign eipsw    = st_q.eipsw;
    assign fepc     = st_q.fepc;
    assign fepsw    = st_q.fepsw;
    assign ecr      = st_q.ecr;

    a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !nmi_req && !exc_req &&
         (psw_in[NP_BIT] || psw_in[EP_BIT] || psw_in[ID_BIT])) |=> !taken);

    a_r3_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !nmi_req && !exc_req &&
         (irq_lvl < psw_in[LVL_LO +: LVL_W])) |=> !taken);

    a_r5_nmi_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> (ecr[CODE_W-1:0] == $past(ecr[CODE_W-1:0])) &&
                    (fepc == $past(nxt_pc)) && (redir_pc == {VEC_HI, NMI_CODE}));

    a_r6_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (psw_new[EP_BIT] && psw_new[ID_BIT]));

    a_r8_exc_saves_cur: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !nmi_req && !irq_req && !psw_in[EP_BIT]) |=>
            (taken && eipc == $past(cur_pc)));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !nmi_req && !exc_req) |=>
            (!taken && $stable(eipc) && $stable(fepc) && $stable(ecr)));
endmodule

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0, nxt_pc = '0, psw_in = '0;
    logic        irq_req = 1'b0, nmi_req = 1'b0, exc_req = 1'b0;
    logic [3:0]  irq_lvl = '0;
    logic [15:0] exc_code = '0;
    logic        taken;
    logic [31:0] redir_pc, psw_new, eipc, eipsw, fepc, fepsw, ecr;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_unit i_exc_entry_unit (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
        .psw_in(psw_in), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .nmi_req(nmi_req), .exc_req(exc_req), .exc_code(exc_code),
        .taken(taken), .redir_pc(redir_pc), .psw_new(psw_new),
        .eipc(eipc), .eipsw(eipsw), .fepc(fepc), .fepsw(fepsw), .ecr(ecr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_psw(input logic [31:0] p, input bit fat);
        logic [31:0] r = p;
        r[19:16] = (p[19:16] == 4'hF) ? 4'hF : p[19:16] + 4'h1;
        r[14] = 1'b1;
        r[12] = 1'b1;
        if (fat) r[15] = 1'b1;
        return r;
    endfunction

    // apply one cycle of requests, then sample after the registering edge
    task automatic step(input logic [31:0] psw, input bit irq, input logic [3:0] lvl,
                        input bit nmi, input bit exc, input logic [15:0] code);
        @(negedge clk);
        cur_pc = 32'h0700_1000 + checks; nxt_pc = cur_pc + 32'h4;
        psw_in = psw; irq_req = irq; irq_lvl = lvl;
        nmi_req = nmi; exc_req = exc; exc_code = code;
        @(negedge clk);
        irq_req = 1'b0; nmi_req = 1'b0; exc_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "taken", {31'b0, taken}, 32'h0);
        chk("R1", "pc", redir_pc, 32'hFFFF_FFF0);
        chk("R1", "psw", psw_new, 32'h0000_8000);
        chk("R1", "ecr", ecr, 32'h0000_FFF0);
        chk("R1", "eipc", eipc, 32'h0);
        chk("R1", "fepsw", fepsw, 32'h0);
    endtask

    task automatic t_irq_basic;
        logic [31:0] p = 32'h0003_0005;
        logic [31:0] sn;
        step(p, 1, 4'h5, 0, 0, 16'h0);
        sn = nxt_pc;
        chk("R7", "irq taken", {31'b0, taken}, 32'h1);
        chk("R7", "irq vector", redir_pc, 32'hFFFF_FE50);
        chk("R4", "ecr low", ecr, 32'h0000_FE50);
        chk("R8", "eipc next", eipc, sn);
        chk("R4", "eipsw", eipsw, p);
        chk("R6", "psw", psw_new, exp_psw(p, 0));
        chk("R4", "fepc untouched", fepc, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] e0 = eipc;
        step(32'h0000_1000, 1, 4'h9, 0, 0, 16'h0);
        chk("R2", "ID masks", {31'b0, taken}, 32'h0);
        step(32'h0000_4000, 1, 4'h9, 0, 0, 16'h0);
        chk("R2", "EP masks", {31'b0, taken}, 32'h0);
        step(32'h0000_8000, 1, 4'h9, 0, 0, 16'h0);
        chk("R2", "NP masks", {31'b0, taken}, 32'h0);
        chk("R2", "eipc unchanged", eipc, e0);
    endtask

    task automatic t_level;
        step(32'h0006_0000, 1, 4'h5, 0, 0, 16'h0);
        chk("R3", "below level", {31'b0, taken}, 32'h0);
        step(32'h0006_0000, 1, 4'h6, 0, 0, 16'h0);
        chk("R3", "equal level", {31'b0, taken}, 32'h1);
        chk("R3", "equal code", ecr[15:0], 32'hFE60);
        step(32'h0006_0000, 1, 4'hA, 0, 0, 16'h0);
        chk("R3", "above level", redir_pc, 32'hFFFF_FEA0);
    endtask

    task automatic t_exc;
        logic [31:0] sc;
        step(32'h0001_0000, 0, 4'h0, 0, 1, 16'hFF80);
        sc = cur_pc;
        chk("R8", "eipc cur", eipc, sc);
        chk("R7", "exc vector", redir_pc, 32'hFFFF_FF80);
        chk("R4", "ecr low", ecr[15:0], 32'hFF80);
        chk("R6", "psw", psw_new, exp_psw(32'h0001_0000, 0));
    endtask

    task automatic t_duplex;
        logic [31:0] p = 32'h0002_5000;
        logic [31:0] lo = ecr;
        logic [31:0] e0 = eipc;
        logic [31:0] sc;
        step(p, 0, 4'h0, 0, 1, 16'hFF80);
        sc = cur_pc;
        chk("R5", "fepc", fepc, sc);
        chk("R5", "fepsw", fepsw, p);
        chk("R5", "ecr", ecr, {16'hFF80, lo[15:0]});
        chk("R5", "vector", redir_pc, 32'hFFFF_FFD0);
        chk("R5", "eipc kept", eipc, e0);
        chk("R6", "psw fatal", psw_new, exp_psw(p, 1));
    endtask

    task automatic t_nmi_prio;
        logic [31:0] lo = ecr;
        logic [31:0] sn;
        step(32'h0000_0000, 1, 4'h3, 1, 1, 16'hFF80);
        sn = nxt_pc;
        chk("R9", "nmi first ecr", ecr, {16'hFFD0, lo[15:0]});
        chk("R8", "nmi saves next", fepc, sn);
        step(32'h0000_0000, 1, 4'h3, 0, 1, 16'hFF80);
        sn = nxt_pc;
        chk("R9", "irq over exc", ecr[15:0], 32'hFE30);
        chk("R9", "irq over exc pc", eipc, sn);
        step(32'h0000_1000, 1, 4'h3, 0, 1, 16'hFF80);
        chk("R9", "masked irq lets exc", ecr[15:0], 32'hFF80);
        chk("R9", "masked irq exc pc", eipc, cur_pc);
    endtask

    task automatic t_sat_hold;
        logic [31:0] e0, f0, c0;
        step(32'h000F_0000, 1, 4'hF, 0, 0, 16'h0);
        chk("R6", "sat level", psw_new[19:16], 32'hF);
        e0 = eipc; f0 = fepc; c0 = ecr;
        @(negedge clk);
        chk("R10", "pulse ends", {31'b0, taken}, 32'h0);
        chk("R10", "hold eipc", eipc, e0);
        chk("R10", "hold fepc", fepc, f0);
        chk("R10", "hold ecr", ecr, c0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_irq_basic();
        t_mask();
        t_level();
        t_exc();
        t_duplex();
        t_nmi_prio();
        t_sat_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule